// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This peripheral drives four independent pulse-width-modulated outputs from one clock. Software configures each channel through a single 32-bit control word. The word holds an enable flag, an 8-bit duty value and a 13-bit prescaler. Each channel's word sits on its own 16-byte aligned slot of a small register window. Writes take effect on the rising clock edge. Reads are combinational from the presented address.

Each running channel divides the clock by the prescaler value plus one to form a step. A period is 256 such steps. The output is high while the step index is below the duty value.

Duty and prescaler changes made while a channel runs are held back until the current period ends, so a period is never cut short. Clearing the enable flag parks the channel with its output low. Setting the flag again starts a fresh period.

Top module: `pwm4_ctrl`

## Requirements
- R1: Channel n (0 to 3) is reached at byte address n*16 (0x00, 0x10, 0x20, 0x30). An address is a channel address only if its low four bits are zero and its upper bits are below 4.
- R2: In a channel word, bit 31 is the enable flag, bits 23:16 are the duty and bits 12:0 are the prescaler. Reads return the last written value with bits 30:24 and 15:13 forced to zero, so writing 0xFFFFFFFF reads back 0x80FF1FFF.
- R3: An address that is not a channel address reads as zero. A write to such an address changes no channel word and no output.
- R4: While enabled, each step lasts prescaler+1 clock cycles and a period is 256 steps. With prescaler 8191 and duty 1, the output stays high for exactly 8192 cycles.
- R5: The output is high while the step index is below the duty. Duty 0 keeps the output low. Duty d gives d*(prescaler+1) high cycles per period, so duty 255 with prescaler 0 gives 255 high cycles out of 256.
- R6: While the enable flag is clear, the output is low and both counters are held at zero. In the first cycle after the write that sets the flag, the period starts at step 0, so the output is high in that cycle whenever the duty is nonzero.
- R7: Duty and prescaler written to a running channel are applied only from the start of the next period. The period in progress finishes with the old values.
- R8: Writing zero to a channel word disables that channel and reads back as zero.
- R9: Reset clears all four channel words and drives all outputs low.
- R10: A write to one channel changes neither the word nor the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
The assertions check the following on every cycle:
- a disabled channel has both counters at zero;
- the step index advances by exactly one when a step's prescale count completes;
- the held duty and prescaler copy only changes at a period boundary or while the channel is stopped;
- stray-address writes leave the register bank untouched;
- outputs are low right after reset.

Only the bench scenarios can show the things that span whole periods:
- the total high time per period for each duty/prescaler pair;
- the exact cycle in which a mid-period update first shows up;
- the readback masking;
- the isolation between channels.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int DUTY_W     = 8;
    localparam int PRE_W      = 13;
    localparam int WORD_W     = 32;
    localparam int EN_POS     = 31;
    localparam int DUTY_LSB   = 16;
    localparam int PRE_LSB    = 0;
    localparam int SLOT_BITS  = 4;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [PRE_W-1:0]  pre_t;

    typedef struct packed {
        logic  en;
        duty_t duty;
        pre_t  pre;
    } chan_cfg_t;

    function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.en   = w[EN_POS];
        c.duty = w[DUTY_LSB +: DUTY_W];
        c.pre  = w[PRE_LSB +: PRE_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w                     = '0;
        w[EN_POS]             = c.en;
        w[DUTY_LSB +: DUTY_W] = c.duty;
        w[PRE_LSB +: PRE_W]   = c.pre;
        return w;
    endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output chan_cfg_t         cfg_o [NUM_CH]
);

    localparam int IDX_W  = ADDR_W - SLOT_BITS;
    localparam int CFG_W  = $bits(chan_cfg_t);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    logic [IDX_W-1:0]        sel;
    logic                    hit;
    chan_cfg_t               cfg_q [NUM_CH];
    logic [NUM_CH*CFG_W-1:0] bank_flat;

    assign sel = addr[ADDR_W-1:SLOT_BITS];
    assign hit = (addr[SLOT_BITS-1:0] == '0) && (sel <= LAST_IDX);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wr && hit && (sel == IDX_W'(i))) begin
                cfg_q[i] <= word_to_cfg(wdata);
            end
        end
        assign cfg_o[i] = cfg_q[i];
        assign bank_flat[i*CFG_W +: CFG_W] = cfg_q[i];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit && (sel == IDX_W'(i))) begin
                rdata = cfg_to_word(cfg_q[i]);
            end
        end
    end

    // R3: a write outside the channel slots leaves every word as it was
    p_stray_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && !hit) |=> $stable(bank_flat));

endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    output logic      pwm_o
);

    pre_t      pre_cnt;
    duty_t     step;
    logic      running;
    chan_cfg_t held;
    chan_cfg_t eff;
    logic      tick;
    logic      wrap;

    // Before the first running cycle the live word is used directly.
    assign eff  = running ? held : cfg;
    assign tick = (pre_cnt == eff.pre);
    assign wrap = tick && (step == {DUTY_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || !cfg.en) begin
            pre_cnt <= '0;
            step    <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            step    <= step + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
        end else begin
            running <= cfg.en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (!running || wrap) begin
            held <= cfg;
        end
    end

    assign pwm_o = cfg.en && (step < eff.duty);

    // R6: a disabled channel parks both counters at zero
    p_park_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (pre_cnt == '0 && step == '0));

    // R4: the step index moves by exactly one when a prescale count completes
    p_step_adv_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && tick) |=> (pre_cnt == '0 && step == duty_t'($past(step) + 1'b1)));

    // R7: the applied settings change only at a period boundary
    p_held_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (running && !wrap) |=> $stable(held));

    // R9: output is low in the first cycle after reset
    p_reset_low_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pwm_o);

endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
    import pwm4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    chan_cfg_t cfg [NUM_CH];

    pwm4_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_o (cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm4_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg[i]),
            .pwm_o (pwm_o[i])
        );
    end

endmodule

// File: tb/pwm4_ctrl_tb.sv
`timescale 1ns/1ps
module pwm4_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pwm4_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    // Vector table: channel, prescaler, duty, expected high cycles per period
    localparam int NV = 7;
    localparam int V_CH   [NV] = '{0, 1, 2, 3, 0, 1, 2};
    localparam int V_PRE  [NV] = '{0, 0, 0, 1, 2, 0, 3};
    localparam int V_DUTY [NV] = '{0, 255, 128, 10, 1, 1, 64};
    localparam int V_HIGH [NV] = '{0, 255, 128, 20, 3, 1, 256};

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge following the write edge.
    task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk(input bit en, input int duty, input int pre);
        return {en, 7'b0, duty[7:0], 3'b0, pre[12:0]};
    endfunction

    // Counts high samples on one channel and any activity on the others.
    task automatic count_high(input int ch, input int n, output int hi, output int others);
        hi = 0; others = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_o[ch]) hi++;
            for (int j = 0; j < 4; j++) if (j != ch && pwm_o[j]) others++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int hi, oth;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        chk("R9 outputs after reset", pwm_o, 0);
        for (int c = 0; c < 4; c++) begin
            rd_word(8'(c*16), r);
            chk("R9 word after reset", r, 0);
        end
        @(negedge clk);

        // R5/R4/R1/R10: vector table, one full period each
        for (int i = 0; i < NV; i++) begin
            wr_word(8'(V_CH[i]*16), mk(1, V_DUTY[i], V_PRE[i]));
            chk("R6 first cycle level", pwm_o[V_CH[i]], (V_DUTY[i] > 0) ? 1 : 0);
            count_high(V_CH[i], 256*(V_PRE[i]+1), hi, oth);
            chk("R5 high cycles per period", hi, V_HIGH[i] > 256*(V_PRE[i]+1) ? 256*(V_PRE[i]+1) : V_HIGH[i]);
            chk("R10 other channels idle", oth, 0);
            rd_word(8'(V_CH[i]*16), r);
            chk("R1 readback at slot", r, mk(1, V_DUTY[i], V_PRE[i]));
            wr_word(8'(V_CH[i]*16), 32'h0);
        end

        // R2: field masking on readback; R8: zero write clears
        wr_word(8'h20, 32'hFFFF_FFFF);
        rd_word(8'h20, r);
        chk("R2 masked readback", r, 32'h80FF_1FFF);
        wr_word(8'h20, 32'h0);
        rd_word(8'h20, r);
        chk("R8 zero write readback", r, 0);
        chk("R8 output after zero write", pwm_o[2], 0);

        // R3: stray addresses
        wr_word(8'h04, 32'hFFFF_FFFF);
        wr_word(8'h44, 32'hFFFF_FFFF);
        wr_word(8'h40, 32'hFFFF_FFFF);
        wr_word(8'hF0, 32'hFFFF_FFFF);
        rd_word(8'h40, r);
        chk("R3 stray read 0x40", r, 0);
        rd_word(8'h08, r);
        chk("R3 stray read 0x08", r, 0);
        for (int c = 0; c < 4; c++) begin
            rd_word(8'(c*16), r);
            chk("R3 slot untouched", r, 0);
        end
        @(negedge clk);
        chk("R3 outputs untouched", pwm_o, 0);

        // R6: disable holds low, keeps settings; re-enable starts fresh
        wr_word(8'h30, mk(1, 255, 0));
        repeat (37) @(negedge clk);
        wr_word(8'h30, mk(0, 255, 0));
        chk("R6 low when disabled", pwm_o[3], 0);
        rd_word(8'h30, r);
        chk("R6 settings kept", r, 32'h00FF_0000);
        repeat (5) @(negedge clk);
        chk("R6 still low", pwm_o[3], 0);
        wr_word(8'h30, mk(1, 255, 0));
        chk("R6 fresh start high", pwm_o[3], 1);
        count_high(3, 256, hi, oth);
        chk("R6 fresh period high count", hi, 255);
        wr_word(8'h30, 32'h0);

        // R7: mid-period update applies at the next period
        wr_word(8'h00, mk(1, 200, 0));
        repeat (10) @(negedge clk);
        wr_word(8'h00, mk(1, 50, 1));
        count_high(0, 245, hi, oth);
        chk("R7 rest of old period", hi, 189);
        count_high(0, 512, hi, oth);
        chk("R7 next period new values", hi, 100);
        wr_word(8'h00, 32'h0);

        // R10: write to one channel leaves another running channel alone
        wr_word(8'h10, mk(1, 255, 0));
        wr_word(8'h20, mk(1, 3, 0));
        rd_word(8'h10, r);
        chk("R10 neighbour word", r, mk(1, 255, 0));
        chk("R10 neighbour output", pwm_o[1], 1);
        wr_word(8'h10, 32'h0);
        wr_word(8'h20, 32'h0);

        // R4: largest prescaler, duty 1 -> one step of 8192 cycles high
        wr_word(8'h00, mk(1, 1, 8191));
        count_high(0, 8200, hi, oth);
        chk("R4 max prescaler step length", hi, 8192);

        // R9: reset while running
        wr_word(8'h10, mk(1, 255, 0));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R9 outputs after mid-run reset", pwm_o, 0);
        rd_word(8'h10, r);
        chk("R9 word after mid-run reset", r, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule